// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives the serial clock of an SPI controller from the controller's reference clock. Two down-counters are cascaded. The first is a prescaler and the second is a post-divider. Together they divide the reference clock by `(1 + post) × pre`. The prescale value must be even, so the overall ratio is always even. The output therefore has a 50% duty cycle and changes level every `ratio/2` reference cycles.

The block has two outputs. `edge_tick` is a one-cycle pulse marking each point where the serial clock changes level. `sclk_ref` is the toggling clock level itself. Surrounding shift logic uses `edge_tick` to launch and capture data, and it uses `sclk_ref` to drive the pin. The block does not compute divider values from a requested frequency. The two fields are supplied ready-made and must be held steady while the divider runs.

The block is controlled by a two-state machine:
- **DIV_IDLE**: both counters are cleared and the outputs sit low.
- **DIV_RUN**: the counters run.

There are two transitions:
- **START** (DIV_IDLE → DIV_RUN): taken when `run_en` is sampled high. It loads both counters.
- **STOP** (DIV_RUN → DIV_IDLE): taken when `run_en` is sampled low. It drops the outputs to the idle level on that same edge.

Top module: `spi_sclk_divider`

## Requirements
- R1: While reset is asserted, and after it is released with `run_en` low, `edge_tick` and `sclk_ref` are both 0.
- R2: While enabled with stable settings, consecutive `edge_tick` pulses are spaced exactly `H = (1 + post_sel) × P / 2` clock cycles apart. P is the effective prescale value.
- R3: The effective prescale P is `pre_sel` with bit 0 cleared. A `pre_sel` of 0 or 1 gives P = 2. For example, 7 behaves like 6, and 1 behaves like 2.
- R4: `sclk_ref` changes level on exactly the clock edge that raises `edge_tick`, and on no other edge while enabled. This gives a 50% duty cycle.
- R5: Let edge 0 be the rising clock edge that first samples `run_en` high. The first `edge_tick` and the first rise of `sclk_ref` both appear after edge H. Neither appears after edge 0.
- R6: A clock edge that samples `run_en` low forces `edge_tick` and `sclk_ref` to 0 at that edge. Re-enabling later restarts the count from the beginning, as in R5.
- R7: The smallest ratio comes from `pre_sel`=2 and `post_sel`=0: `edge_tick` is high on every cycle and `sclk_ref` toggles every cycle. The largest ratio comes from `pre_sel`=254 and `post_sel`=255: H = 32512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Run enable; low clears the divider |
| pre_sel | input | 8 | Prescale value (even, 2..254) |
| post_sel | input | 8 | Post-divide value (0..255) |
| edge_tick | output | 1 | One-cycle pulse at each serial clock edge point |
| sclk_ref | output | 1 | Divided serial clock level, idle low |

## Verification
The bench targets the following corner cases:
- **Odd prescale values, 0 and 1.** A design that skips the rounding would produce an odd ratio. A design without the floor would produce a zero-length prescale period, and both show up as wrong tick spacing.
- **The minimum ratio, where the tick never drops.** An off-by-one reload would show up here as gaps between ticks.
- **The maximum ratio.** This exposes counters that are too narrow.
- **The first tick after enabling.** A design that loads late or early would shift the whole pattern by a cycle.
- **A mid-run disable.** A divider that did not clear would resume from a stale count, or leave the clock stuck high.

// File: rtl/spi_sclk_div_pkg.sv
package spi_sclk_div_pkg;

    typedef enum logic [0:0] {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/spi_sclk_pre_norm.sv
// Turns the raw prescale field into the reload value of the half-prescale
// counter: (P/2 - 1), where P is the field with bit 0 cleared, floored at 2.
module spi_sclk_pre_norm #(
    parameter int PRE_W = 8
) (
    input  logic [PRE_W-1:0] pre_raw,
    output logic [PRE_W-2:0] half_m1
);
    localparam int HW = PRE_W - 1;

    logic [HW-1:0] half_raw;

    always_comb begin
        half_raw = pre_raw[PRE_W-1:1];
        if (half_raw == '0) begin
            half_m1 = '0;
        end else begin
            half_m1 = half_raw - HW'(1);
        end
    end
endmodule

// File: rtl/spi_sclk_count_stage.sv
// Reloading down-counter: wraps to reload_val after reaching zero on a step.
module spi_sclk_count_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] reload_val,
    output logic         wrap
);
    logic [W-1:0] cnt_q;
    logic         at_zero;

    assign at_zero = (cnt_q == '0);
    assign wrap    = step && at_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload_val;
        end else if (step) begin
            if (at_zero) begin
                cnt_q <= reload_val;
            end else begin
                cnt_q <= cnt_q - W'(1);
            end
        end
    end
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
    import spi_sclk_div_pkg::*;
#(
    parameter int PRE_W  = 8,
    parameter int POST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [PRE_W-1:0]  pre_sel,
    input  logic [POST_W-1:0] post_sel,
    output logic              edge_tick,
    output logic              sclk_ref
);
    localparam int HALF_W = PRE_W - 1;

    div_state_e        state_q;
    div_state_e        state_d;
    logic [HALF_W-1:0] half_pre_m1;
    logic              do_start;
    logic              do_count;
    logic              pre_wrap;
    logic              post_wrap;

    spi_sclk_pre_norm #(.PRE_W(PRE_W)) u_norm (
        .pre_raw (pre_sel),
        .half_m1 (half_pre_m1)
    );

    assign do_start = (state_q == DIV_IDLE) && run_en;
    assign do_count = (state_q == DIV_RUN) && run_en;

    spi_sclk_count_stage #(.W(HALF_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!run_en),
        .load       (do_start),
        .step       (do_count),
        .reload_val (half_pre_m1),
        .wrap       (pre_wrap)
    );

    spi_sclk_count_stage #(.W(POST_W)) u_post (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!run_en),
        .load       (do_start),
        .step       (pre_wrap),
        .reload_val (post_sel),
        .wrap       (post_wrap)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIV_IDLE: if (run_en)  state_d = DIV_RUN;   // START
            DIV_RUN:  if (!run_en) state_d = DIV_IDLE;  // STOP
            default:  state_d = DIV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_tick <= 1'b0;
            sclk_ref  <= 1'b0;
        end else begin
            unique case (state_q)
                DIV_IDLE: begin
                    edge_tick <= 1'b0;
                    sclk_ref  <= 1'b0;
                end
                DIV_RUN: begin
                    if (!run_en) begin
                        edge_tick <= 1'b0;
                        sclk_ref  <= 1'b0;
                    end else begin
                        edge_tick <= post_wrap;
                        if (post_wrap) begin
                            sclk_ref <= ~sclk_ref;
                        end
                    end
                end
                default: begin
                    edge_tick <= 1'b0;
                    sclk_ref  <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_sclk_divider_chk.sv
module spi_sclk_divider_chk #(
    parameter int PRE_W  = 8,
    parameter int POST_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic [PRE_W-1:0]  pre_sel,
    input logic [POST_W-1:0] post_sel,
    input logic              edge_tick,
    input logic              sclk_ref
);
    localparam int GAP_W = PRE_W + POST_W + 1;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    logic [GAP_W-1:0] pre_eff;
    logic [GAP_W-1:0] half_exp;

    always_comb begin
        pre_eff = GAP_W'({pre_sel[PRE_W-1:1], 1'b0});
        if (pre_eff < GAP_W'(2)) pre_eff = GAP_W'(2);
        half_exp = ((GAP_W'(post_sel) + GAP_W'(1)) * pre_eff) >> 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (!run_en) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (edge_tick) begin
            gap_q  <= GAP_W'(1);
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!edge_tick && !sclk_ref)) else $error("idle"); // R6

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_tick && seen_q && run_en) |-> (gap_q == half_exp)) else $error("spacing"); // R2

    AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        edge_tick |-> (sclk_ref != $past(sclk_ref))) else $error("toggle"); // R4

    AST_TOGGLE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ((sclk_ref != $past(sclk_ref)) && $past(run_en)) |-> edge_tick) else $error("stray"); // R4

    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |=> !edge_tick) else $error("early"); // R5
endmodule

bind spi_sclk_divider spi_sclk_divider_chk #(.PRE_W(PRE_W), .POST_W(POST_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .pre_sel   (pre_sel),
    .post_sel  (post_sel),
    .edge_tick (edge_tick),
    .sclk_ref  (sclk_ref)
);

// File: tb/tb_spi_sclk_divider.sv
module tb_spi_sclk_divider;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       run_en;
    logic [7:0] pre_sel;
    logic [7:0] post_sel;
    logic       edge_tick;
    logic       sclk_ref;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    spi_sclk_divider dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .pre_sel   (pre_sel),
        .post_sel  (post_sel),
        .edge_tick (edge_tick),
        .sclk_ref  (sclk_ref)
    );

    function automatic int exp_half(input logic [7:0] p, input logic [7:0] q);
        int pe;
        pe = int'(p) & 32'hFE;       // R3: clear bit 0
        if (pe < 2) pe = 2;          // R3: floor at 2
        return ((int'(q) + 1) * pe) / 2;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Enables with the given fields, compares every cycle, then disables.
    task automatic run_case(input logic [7:0] p, input logic [7:0] q,
                            input int ncyc, input string tag);
        int  h;
        bit  et;
        bit  es;
        h = exp_half(p, q);
        @(negedge clk);
        pre_sel  = p;
        post_sel = q;
        run_en   = 1'b1;
        for (int k = 0; k <= ncyc; k++) begin
            @(negedge clk);
            et = (k > 0) && (k % h == 0);
            es = ((k / h) % 2) == 1;
            if (k == h) begin
                check(edge_tick == 1'b1, {tag, " R5 first tick"}, edge_tick, 1);
                check(sclk_ref == 1'b1, {tag, " R5 first rise"}, sclk_ref, 1);
            end else begin
                check(edge_tick == et, {tag, " R2 tick"}, edge_tick, et);
                check(sclk_ref == es, {tag, " R4 level"}, sclk_ref, es);
            end
        end
        run_en = 1'b0;
        @(negedge clk);
        check(edge_tick == 1'b0, "R6 tick after disable", edge_tick, 0);
        check(sclk_ref == 1'b0, "R6 level after disable", sclk_ref, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n    = 1'b0;
        run_en   = 1'b0;
        pre_sel  = 8'd2;
        post_sel = 8'd0;
        repeat (3) @(negedge clk);
        check(edge_tick == 1'b0, "R1 tick in reset", edge_tick, 0);
        check(sclk_ref == 1'b0, "R1 level in reset", sclk_ref, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(edge_tick == 1'b0, "R1 tick idle", edge_tick, 0);
        check(sclk_ref == 1'b0, "R1 level idle", sclk_ref, 0);

        run_case(8'd2, 8'd0, 12, "R7 min");
        run_case(8'd4, 8'd0, 12, "R2 pre4");
        run_case(8'd2, 8'd3, 20, "R2 post3");
        run_case(8'd7, 8'd1, 30, "R3 odd7");
        run_case(8'd1, 8'd2, 15, "R3 one");
        run_case(8'd0, 8'd2, 15, "R3 zero");
        run_case(8'd255, 8'd0, 300, "R3 odd255");

        // R6: disable partway through a half period, then restart cleanly
        run_case(8'd10, 8'd4, 37, "R6 cut");
        run_case(8'd10, 8'd4, 60, "R6 restart");

        for (int i = 0; i < 20; i++) begin
            logic [7:0] p;
            logic [7:0] q;
            p = 8'($urandom % 256);
            q = 8'($urandom % 8);
            run_case(p, q, 3 * exp_half(p, q) + 2, "R2 rand");
        end

        run_case(8'd254, 8'd255, 32512 + 3, "R7 max");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule